// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Guard

This block keeps the eight-bit status byte of a serial NOR flash and makes every write-protection decision for it. A command decoder in front of it presents one-cycle strobes: set write latch, clear write latch, arm the volatile status path, status write with its data byte, page program, sector erase, block erase and chip erase with a target byte address, plus a strobe for any other decoded command. The block answers each modifying request with a one-cycle permit or deny pulse, raises a busy flag for the self-timed cycle it starts, and drops busy when the program/erase timer reports completion.

The non-volatile part of the register (lock bit and the three protect-range bits) is modelled as plain flops loaded from a reset value. A shadow copy holds the effective bits. A status write made right after arming the volatile path updates only the shadow, at once and without a busy cycle. The protect-range code locks a growing group of blocks counted down from the top of the array.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 00h, busy is 0, and both permit and deny are 0.
- R2: A set-latch strobe sets the write latch (bit 1) and a clear-latch strobe clears it; each shows on the status byte one cycle later.
- R3: Program, sector erase, block erase, chip erase and a non-volatile status write are denied while the write latch is 0; a denied request leaves the status byte unchanged, including the write latch.
- R4: With a protect code in bits 4:2 of 000, 001, 010 or 011, no blocks, the top block, the top two or the top four blocks of eight (64 KB each, block index = address bits 18:16) are locked; codes 100 to 111 lock all blocks. Program, sector erase and block erase aimed at a locked block are denied.
- R5: Chip erase is denied whenever any protect bit is 1 and permitted with code 000 and the latch set.
- R6: Bit 0 (busy) and the busy output are 1 from the cycle after a permitted program, erase or non-volatile status write until the cycle after the completion strobe; in that cycle the write latch is also 0.
- R7: Every modifying request made while busy is 1 is denied.
- R8: A non-volatile status write changes only bits 7 and 4:2 (bits 6, 5 read 0; bits 1, 0 follow the latch and busy), and its new value appears one cycle after completion.
- R9: Once bit 7 (lock) is 1, every status write is denied and bit 7 never returns to 0 until reset.
- R10: Arming the volatile path does not set the write latch; a status write as the very next command is permitted without the latch, updates bits 7 and 4:2 one cycle later and never raises busy.
- R11: Any other command between arming and the status write disarms the volatile path, so the status write then follows the non-volatile rules.
- R12: Each request yields exactly one of permit or deny, as a single-cycle pulse in the cycle after the request strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel_set_i | input | 1 | Set write latch strobe |
| wel_clr_i | input | 1 | Clear write latch strobe |
| vol_arm_i | input | 1 | Arm volatile status-write path |
| sr_write_i | input | 1 | Status write request |
| sr_data_i | input | 8 | Data byte of the status write |
| prog_i | input | 1 | Page program request |
| sect_erase_i | input | 1 | Sector erase request |
| blk_erase_i | input | 1 | Block erase request |
| chip_erase_i | input | 1 | Chip erase request |
| req_addr_i | input | ADDR_W (19) | Target byte address for program and erases |
| other_cmd_i | input | 1 | Any other decoded command |
| op_done_i | input | 1 | Completion strobe from the program/erase timer |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Request permitted (one-cycle pulse) |
| deny_o | output | 1 | Request refused (one-cycle pulse) |
| busy_o | output | 1 | Self-timed cycle in progress |

## Verification
Every result of this block is one register stage away from its cause: the permit or deny pulse, a latch change, busy rising and a volatile status update all appear one cycle after the strobe, and busy falling, latch clearing and a non-volatile status update appear one cycle after the completion strobe. The bench drives each strobe on a falling edge for a single cycle and reads the outputs at the following falling edge, half a period after the rising edge that registered them, so each check lands exactly on the cycle the result is due. The pulse nature of permit and deny is confirmed by a further read one cycle later.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int SR_W      = 8;
  localparam int BIT_LOCK  = 7;
  localparam int BIT_BP_HI = 4;
  localparam int BIT_BP_LO = 2;
  localparam int BIT_WEL   = 1;
  localparam int BIT_BUSY  = 0;
  localparam int BP_W      = BIT_BP_HI - BIT_BP_LO + 1;
  localparam int PROT_W    = BP_W + 1;

  // lock bit over protect code, as held in the backing and shadow copies
  typedef struct packed {
    logic            lock;
    logic [BP_W-1:0] bp;
  } prot_t;

  function automatic prot_t prot_from_byte(input logic [SR_W-1:0] b);
    prot_t p;
    p.lock = b[BIT_LOCK];
    p.bp   = b[BIT_BP_HI:BIT_BP_LO];
    return p;
  endfunction
endpackage

// File: rtl/fsg_protect_decode.sv
module fsg_protect_decode
  import fsg_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_IDX_W = $clog2(NUM_BLOCKS),
  localparam int LOG_NB    = $clog2(NUM_BLOCKS)
) (
  input  logic [BP_W-1:0]      bp_i,
  input  logic [BLK_IDX_W-1:0] blk_idx_i,
  output logic                 blk_locked_o,
  output logic                 any_bp_o
);
  logic [BLK_IDX_W:0]    lock_cnt;
  logic [NUM_BLOCKS-1:0] lock_mask;

  always_comb begin
    if (bp_i == '0) begin
      lock_cnt = '0;
    end else if (int'(bp_i) > LOG_NB) begin
      lock_cnt = (BLK_IDX_W+1)'(NUM_BLOCKS);
    end else begin
      lock_cnt = (BLK_IDX_W+1)'(1) << (bp_i - BP_W'(1));
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_mask
    assign lock_mask[b] = (lock_cnt != '0) && (b >= (NUM_BLOCKS - int'(lock_cnt)));
  end

  assign blk_locked_o = lock_mask[blk_idx_i];
  assign any_bp_o     = |bp_i;
endmodule

// File: rtl/fsg_busy_tracker.sv
module fsg_busy_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o,
  output logic finish_o
);
  logic busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (busy_q) begin
      if (done_i) busy_d = 1'b0;
    end else if (start_i) begin
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o   = busy_q;
  assign finish_o = busy_q & done_i;
endmodule

// File: rtl/fsg_status_store.sv
module fsg_status_store
  import fsg_pkg::*;
#(
  parameter logic [PROT_W-1:0] NV_INIT = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_wel_i,
  input  logic  clr_wel_i,
  input  logic  nv_start_i,
  input  logic  vol_wr_i,
  input  prot_t wr_prot_i,
  input  logic  finish_i,
  output prot_t eff_o,
  output logic  wel_o
);
  logic  wel_q, wel_d;
  prot_t nv_q, nv_d, sh_q, sh_d, pend_q, pend_d;
  logic  pend_vld_q, pend_vld_d;
  logic  nv_en, sh_en, pend_en;

  always_comb begin
    wel_d      = wel_q;
    nv_d       = nv_q;
    sh_d       = sh_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    nv_en      = 1'b0;
    sh_en      = 1'b0;
    pend_en    = 1'b0;

    if (finish_i || clr_wel_i) wel_d = 1'b0;
    else if (set_wel_i)        wel_d = 1'b1;

    if (nv_start_i) begin
      pend_en    = 1'b1;
      pend_d     = wr_prot_i;
      pend_vld_d = 1'b1;
    end

    if (finish_i && pend_vld_q) begin
      nv_en      = 1'b1;
      sh_en      = 1'b1;
      pend_en    = 1'b1;
      pend_vld_d = 1'b0;
      nv_d.lock  = nv_q.lock | pend_q.lock;
      nv_d.bp    = pend_q.bp;
      sh_d       = nv_d;
    end else if (vol_wr_i) begin
      sh_en      = 1'b1;
      sh_d.lock  = sh_q.lock | wr_prot_i.lock;
      sh_d.bp    = wr_prot_i.bp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     nv_q <= NV_INIT;
    else if (nv_en) nv_q <= nv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= NV_INIT;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else if (pend_en) begin
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  assign eff_o = sh_q;
  assign wel_o = wel_q;
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int                NUM_BLOCKS  = 8,
  parameter int                BLOCK_BYTES = 65536,
  parameter logic [PROT_W-1:0] NV_INIT     = '0,
  localparam int BLK_IDX_W = $clog2(NUM_BLOCKS),
  localparam int OFS_W     = $clog2(BLOCK_BYTES),
  localparam int ADDR_W    = BLK_IDX_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              vol_arm_i,
  input  logic              sr_write_i,
  input  logic [SR_W-1:0]   sr_data_i,
  input  logic              prog_i,
  input  logic              sect_erase_i,
  input  logic              blk_erase_i,
  input  logic              chip_erase_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              other_cmd_i,
  input  logic              op_done_i,
  output logic [SR_W-1:0]   status_o,
  output logic              grant_o,
  output logic              deny_o,
  output logic              busy_o
);
  logic  busy, finish, wel, blk_locked, any_bp;
  prot_t eff;
  logic  any_cmd, any_req, permit, start, vol_wr;
  logic  vol_armed_q, vol_armed_d;
  logic  grant_q, grant_d, deny_q, deny_d;

  assign any_req = sr_write_i | prog_i | sect_erase_i | blk_erase_i | chip_erase_i;
  assign any_cmd = any_req | wel_set_i | wel_clr_i | vol_arm_i | other_cmd_i;

  fsg_protect_decode #(.NUM_BLOCKS(NUM_BLOCKS)) u_decode (
    .bp_i         (eff.bp),
    .blk_idx_i    (req_addr_i[ADDR_W-1 -: BLK_IDX_W]),
    .blk_locked_o (blk_locked),
    .any_bp_o     (any_bp)
  );

  // request arbitration: status write, then program, then the erases
  always_comb begin
    permit = 1'b0;
    start  = 1'b0;
    vol_wr = 1'b0;
    if (!busy) begin
      if (sr_write_i) begin
        if (vol_armed_q) begin
          vol_wr = !eff.lock;
          permit = vol_wr;
        end else begin
          permit = wel && !eff.lock;
          start  = permit;
        end
      end else if (prog_i || sect_erase_i || blk_erase_i) begin
        permit = wel && !blk_locked;
        start  = permit;
      end else if (chip_erase_i) begin
        permit = wel && !any_bp;
        start  = permit;
      end
    end
  end

  always_comb begin
    vol_armed_d = vol_armed_q;
    if (vol_arm_i && !busy) vol_armed_d = 1'b1;
    else if (any_cmd)       vol_armed_d = 1'b0;
    grant_d = any_req & permit;
    deny_d  = any_req & ~permit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_armed_q <= 1'b0;
      grant_q     <= 1'b0;
      deny_q      <= 1'b0;
    end else begin
      vol_armed_q <= vol_armed_d;
      grant_q     <= grant_d;
      deny_q      <= deny_d;
    end
  end

  fsg_busy_tracker u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .done_i   (op_done_i),
    .busy_o   (busy),
    .finish_o (finish)
  );

  fsg_status_store #(.NV_INIT(NV_INIT)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_wel_i  (wel_set_i && !busy),
    .clr_wel_i  (wel_clr_i && !busy),
    .nv_start_i (start && sr_write_i),
    .vol_wr_i   (vol_wr),
    .wr_prot_i  (prot_from_byte(sr_data_i)),
    .finish_i   (finish),
    .eff_o      (eff),
    .wel_o      (wel)
  );

  always_comb begin
    status_o                       = '0;
    status_o[BIT_LOCK]             = eff.lock;
    status_o[BIT_BP_HI:BIT_BP_LO]  = eff.bp;
    status_o[BIT_WEL]              = wel;
    status_o[BIT_BUSY]             = busy;
  end

  assign grant_o = grant_q;
  assign deny_o  = deny_q;
  assign busy_o  = busy;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status_o,
  input logic       grant_o,
  input logic       deny_o,
  input logic       busy_o
);
  // R12
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && deny_o));

  // R6
  busy_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> grant_o);

  // R6
  busy_bit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] == busy_o);

  // R6
  wel_clear_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !status_o[1]);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:5] == 2'b00);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(status_o[7]));

  // R9
  bp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status_o[7]) |-> $stable(status_o[4:2]));
endmodule

bind flash_status_guard fsg_checker u_fsg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .status_o (status_o),
  .grant_o  (grant_o),
  .deny_o   (deny_o),
  .busy_o   (busy_o)
);

// File: tb/tb_flash_status_guard.sv
module tb_flash_status_guard;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;

  localparam int K_WREN  = 0;
  localparam int K_WRDI  = 1;
  localparam int K_ARM   = 2;
  localparam int K_SRW   = 3;
  localparam int K_PROG  = 4;
  localparam int K_SE    = 5;
  localparam int K_BE    = 6;
  localparam int K_CE    = 7;
  localparam int K_OTHER = 8;
  localparam int K_DONE  = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wel_set_i, wel_clr_i, vol_arm_i, sr_write_i;
  logic [7:0]        sr_data_i;
  logic              prog_i, sect_erase_i, blk_erase_i, chip_erase_i;
  logic [ADDR_W-1:0] req_addr_i;
  logic              other_cmd_i, op_done_i;
  logic [7:0]        status_o;
  logic              grant_o, deny_o, busy_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_guard dut (
    .clk(clk), .rst_n(rst_n),
    .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i), .vol_arm_i(vol_arm_i),
    .sr_write_i(sr_write_i), .sr_data_i(sr_data_i),
    .prog_i(prog_i), .sect_erase_i(sect_erase_i), .blk_erase_i(blk_erase_i),
    .chip_erase_i(chip_erase_i), .req_addr_i(req_addr_i),
    .other_cmd_i(other_cmd_i), .op_done_i(op_done_i),
    .status_o(status_o), .grant_o(grant_o), .deny_o(deny_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    wel_set_i = 0; wel_clr_i = 0; vol_arm_i = 0; sr_write_i = 0; sr_data_i = '0;
    prog_i = 0; sect_erase_i = 0; blk_erase_i = 0; chip_erase_i = 0;
    req_addr_i = '0; other_cmd_i = 0; op_done_i = 0;
  endtask

  // drive one strobe for one cycle; outputs for it are readable on return
  task automatic issue(input int k, input logic [7:0] d = 8'h00, input logic [ADDR_W-1:0] a = '0);
    @(negedge clk);
    sr_data_i = d;
    req_addr_i = a;
    case (k)
      K_WREN:  wel_set_i = 1;
      K_WRDI:  wel_clr_i = 1;
      K_ARM:   vol_arm_i = 1;
      K_SRW:   sr_write_i = 1;
      K_PROG:  prog_i = 1;
      K_SE:    sect_erase_i = 1;
      K_BE:    blk_erase_i = 1;
      K_CE:    chip_erase_i = 1;
      K_OTHER: other_cmd_i = 1;
      default: op_done_i = 1;
    endcase
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic do_reset();
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic verdict(input string req, input int g);
    check(req, "grant", int'(grant_o), g);
    check(req, "deny", int'(deny_o), 1 - g);
  endtask

  // set protect bits through a full non-volatile write
  task automatic load_status(input logic [7:0] d);
    issue(K_WREN);
    issue(K_SRW, d);
    issue(K_DONE);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "status", int'(status_o), 'h00);
    check("R1", "busy", int'(busy_o), 0);
    check("R1", "grant", int'(grant_o), 0);
    check("R1", "deny", int'(deny_o), 0);
  endtask

  task automatic t_latch();
    issue(K_WREN);
    check("R2", "status after set", int'(status_o), 'h02);
    issue(K_WRDI);
    check("R2", "status after clear", int'(status_o), 'h00);
  endtask

  task automatic t_no_latch();
    issue(K_PROG, 8'h00, 19'h00000);
    verdict("R3", 0);
    check("R3", "status after denied program", int'(status_o), 'h00);
    issue(K_SRW, 8'h0C);
    verdict("R3", 0);
    check("R3", "status after denied write", int'(status_o), 'h00);
  endtask

  task automatic t_program();
    issue(K_WREN);
    issue(K_PROG, 8'h00, 19'h00100);
    verdict("R12", 1);
    check("R6", "status while busy", int'(status_o), 'h03);
    check("R6", "busy out", int'(busy_o), 1);
    @(negedge clk);
    check("R12", "grant one cycle", int'(grant_o), 0);
    issue(K_SE, 8'h00, 19'h10000);
    verdict("R7", 0);
    issue(K_WREN);
    check("R7", "status unchanged while busy", int'(status_o), 'h03);
    issue(K_DONE);
    check("R6", "status after done", int'(status_o), 'h00);
    check("R6", "busy after done", int'(busy_o), 0);
  endtask

  task automatic t_nv_write();
    issue(K_WREN);
    issue(K_SRW, 8'h6B);
    verdict("R8", 1);
    check("R8", "old bits during cycle", int'(status_o), 'h03);
    issue(K_DONE);
    check("R8", "masked value applied", int'(status_o), 'h08);
  endtask

  task automatic t_protect();
    // code 010: blocks 6 and 7 locked
    issue(K_WREN);
    issue(K_PROG, 8'h00, 19'h70000);
    verdict("R4", 0);
    check("R3", "latch kept on deny", int'(status_o), 'h0A);
    issue(K_SE, 8'h00, 19'h61234);
    verdict("R4", 0);
    issue(K_CE);
    verdict("R5", 0);
    issue(K_BE, 8'h00, 19'h5FFFF);
    verdict("R4", 1);
    issue(K_DONE);
    // code 011: blocks 4..7
    load_status(8'h0C);
    check("R4", "code 011 loaded", int'(status_o), 'h0C);
    issue(K_WREN);
    issue(K_PROG, 8'h00, 19'h40000);
    verdict("R4", 0);
    issue(K_PROG, 8'h00, 19'h3FFFF);
    verdict("R4", 1);
    issue(K_DONE);
    // code 100: all
    load_status(8'h10);
    issue(K_WREN);
    issue(K_PROG, 8'h00, 19'h00000);
    verdict("R4", 0);
    issue(K_WRDI);
    // code 001: block 7 only
    load_status(8'h04);
    issue(K_WREN);
    issue(K_BE, 8'h00, 19'h70000);
    verdict("R4", 0);
    issue(K_PROG, 8'h00, 19'h6FFFF);
    verdict("R4", 1);
    issue(K_DONE);
    issue(K_WREN);
    issue(K_CE);
    verdict("R5", 0);
    issue(K_WRDI);
    // code 000: chip erase allowed
    load_status(8'h00);
    issue(K_WREN);
    issue(K_CE);
    verdict("R5", 1);
    issue(K_DONE);
    check("R5", "status after chip erase", int'(status_o), 'h00);
  endtask

  task automatic t_volatile();
    issue(K_ARM);
    check("R10", "arm leaves latch", int'(status_o), 'h00);
    issue(K_SRW, 8'h08);
    verdict("R10", 1);
    check("R10", "shadow applied", int'(status_o), 'h08);
    check("R10", "no busy", int'(busy_o), 0);
    issue(K_ARM);
    issue(K_OTHER);
    issue(K_SRW, 8'h00);
    verdict("R11", 0);
    check("R11", "status kept", int'(status_o), 'h08);
    issue(K_ARM);
    issue(K_WREN);
    check("R11", "latch set", int'(status_o), 'h0A);
    issue(K_SRW, 8'h00);
    verdict("R11", 1);
    check("R11", "non-volatile path taken", int'(status_o), 'h0B);
    issue(K_DONE);
    check("R11", "value after done", int'(status_o), 'h00);
  endtask

  task automatic t_lock();
    load_status(8'h84);
    check("R9", "lock set", int'(status_o), 'h84);
    issue(K_WREN);
    issue(K_SRW, 8'h00);
    verdict("R9", 0);
    check("R9", "status frozen", int'(status_o), 'h86);
    issue(K_ARM);
    issue(K_SRW, 8'h00);
    verdict("R9", 0);
    check("R9", "volatile write blocked", int'(status_o), 'h86);
  endtask

  initial begin
    rst_n = 0;
    clear_inputs();
    t_reset();
    t_latch();
    t_no_latch();
    t_program();
    t_nv_write();
    t_protect();
    t_volatile();
    t_lock();
    t_reset();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule